// File: doc/BRIEF.md
# Period Trim Controller

This block trims a local oscillator against an external event of known period, for example a pulse derived from the mains. A free-running timer runs on the local clock. The timer value is sampled whenever a qualifying event edge arrives. Events are taken in pairs: the first sample is held, and the second sample has the held value subtracted from it to give the measured interval in local clock cycles.

The interval is compared with a programmed expected count, widened by a programmed tolerance, and a signed tuning code is nudged by one step. The step is downward when the interval is too long, because the local clock is running fast. It is upward when the interval is too short, because the local clock is running slow. The tuning code feeds the oscillator's trim input, and a one-cycle strobe marks each finished comparison.

The control is a three-state machine:
- **ST_ARM** waits for the first qualified event. On that event (transition ARM→SPAN) the first capture is taken.
- **ST_SPAN** waits for the second qualified event. On that event (transition SPAN→EVAL) the second capture and the interval are taken.
- **ST_EVAL** lasts one cycle. The tuning code is updated and the machine returns unconditionally (transition EVAL→ARM).

A qualified event that arrives while the machine is in ST_EVAL is dropped.

Top module: `ptrim_ctrl`

## Requirements
- R1: After reset the tuning code is 00000, `cap_first`, `cap_last` and `meas_delta` are zero, and `cap_stb` and `meas_done` are low.
- R2: The event input passes through a synchronizer, and `cfg_edge` selects which edges qualify:
  - 00 selects rising edges.
  - 01 selects falling edges.
  - 10 selects every fourth rising edge, counted from the moment the mode is selected.
  - 11 behaves as 00.
- R3: On the first qualified event of a pair, `cap_first` takes the timer value and holds it until the next pair begins. `cap_stb` is high for exactly one cycle per capture.
- R4: On the second qualified event, `cap_last` takes the timer value and `meas_delta` becomes `cap_last - cap_first` modulo 2^TW. The result is the true interval even when the timer wraps between the two events.
- R5: When `meas_delta > cfg_expect + cfg_tol`, the tuning code decreases by one.
- R6: When `meas_delta + cfg_tol < cfg_expect`, the tuning code increases by one.
- R7: When `meas_delta` lies inside the band, including both band edges, the tuning code is unchanged.
- R8: The tuning code is TUNE_W-bit two's complement. It saturates at 01111 and at 10000 and never wraps.
- R9: `meas_done` is high for exactly one cycle after each comparison, and the updated tuning code is already visible in that cycle. The tuning code changes in no other cycle.
- R10: Measurements do not overlap. After a comparison, the next qualified event starts a new pair as a fresh first capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_async | input | 1 | External event, asynchronous to `clk` |
| cfg_expect | input | TW | Expected interval in clock cycles |
| cfg_tol | input | TW | Half-width of the no-change band |
| cfg_edge | input | 2 | Edge qualifier select (see R2) |
| cap_first | output | TW | Timer value at the first event of a pair |
| cap_last | output | TW | Timer value at the second event of a pair |
| meas_delta | output | TW | Measured interval, modulo 2^TW |
| tune_code | output | TUNE_W | Signed oscillator tuning code |
| cap_stb | output | 1 | One-cycle pulse per capture |
| meas_done | output | 1 | One-cycle pulse after each comparison |

## Verification
The assertions check the following on every cycle:
- the single-cycle shape of both strobes;
- the modular relation between `meas_delta` and the two captures;
- the direction of each tuning step against the band, and the absence of wrap at the two end codes;
- that the tuning code holds still outside `meas_done`.

Other behaviour only the bench's scenarios can show:
- which edges qualify in each select mode, including the divide-by-four grouping and the falling-edge case, where pulse widths are deliberately unequal;
- that a wrap of the timer really occurs inside an interval;
- the walk of the code into both saturation limits through long runs of one-sided measurements.

// File: rtl/ptrim_pkg.sv
package ptrim_pkg;

    typedef enum logic [1:0] {
        ST_ARM  = 2'b00,
        ST_SPAN = 2'b01,
        ST_EVAL = 2'b10
    } ptrim_state_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_QUAD = 2'b10,
        EDGE_ALT  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        TRIM_HOLD = 2'b00,
        TRIM_UP   = 2'b01,
        TRIM_DOWN = 2'b10
    } trim_dir_e;

endpackage

// File: rtl/ptrim_evt_qual.sv
module ptrim_evt_qual
    import ptrim_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRESCALE    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_async,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(PRESCALE - 1);
    localparam logic [CW-1:0] DIV_ONE  = CW'(1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [CW-1:0]          div_q;
    logic                   lvl;
    logic                   rise;
    logic                   fall;
    logic                   group_end;

    // synchronizer chain, one flop per stage
    for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
        if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[gi] <= 1'b0;
                else        sync_q[gi] <= evt_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[gi] <= 1'b0;
                else        sync_q[gi] <= sync_q[gi-1];
            end
        end
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise      = lvl & ~prev_q;
    assign fall      = ~lvl & prev_q;
    assign group_end = (div_q == DIV_LAST);

    // rising-edge group counter, only active in divide mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (edge_sel != EDGE_QUAD) begin
            div_q <= '0;
        end else if (rise) begin
            div_q <= group_end ? '0 : div_q + DIV_ONE;
        end
    end

    always_comb begin
        unique case (edge_sel)
            EDGE_FALL: hit = fall;
            EDGE_QUAD: hit = rise & group_end;
            default:   hit = rise;
        endcase
    end

endmodule

// File: rtl/ptrim_timer.sv
module ptrim_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] count
);
    localparam logic [TW-1:0] STEP = TW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + STEP;
    end

endmodule

// File: rtl/ptrim_judge.sv
module ptrim_judge
    import ptrim_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic [TW-1:0] delta,
    input  logic [TW-1:0] expect_cnt,
    input  logic [TW-1:0] tol,
    output trim_dir_e     dir
);
    localparam int EW = TW + 1;

    logic [EW-1:0] delta_x;
    logic [EW-1:0] upper_x;
    logic [EW-1:0] lifted_x;
    logic [EW-1:0] expect_x;

    assign delta_x  = {1'b0, delta};
    assign expect_x = {1'b0, expect_cnt};
    assign upper_x  = expect_x + {1'b0, tol};
    assign lifted_x = delta_x + {1'b0, tol};

    always_comb begin
        if (delta_x > upper_x)       dir = TRIM_DOWN;
        else if (lifted_x < expect_x) dir = TRIM_UP;
        else                          dir = TRIM_HOLD;
    end

endmodule

// File: rtl/ptrim_tune.sv
module ptrim_tune
    import ptrim_pkg::*;
#(
    parameter int TUNE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  trim_dir_e         dir,
    output logic [TUNE_W-1:0] code
);
    localparam logic [TUNE_W-1:0] CODE_MAX = {1'b0, {(TUNE_W-1){1'b1}}};
    localparam logic [TUNE_W-1:0] CODE_MIN = {1'b1, {(TUNE_W-1){1'b0}}};
    localparam logic [TUNE_W-1:0] ONE      = TUNE_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
        end else if (apply) begin
            unique case (dir)
                TRIM_UP:   if (code != CODE_MAX) code <= code + ONE;
                TRIM_DOWN: if (code != CODE_MIN) code <= code - ONE;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/ptrim_ctrl.sv
module ptrim_ctrl
    import ptrim_pkg::*;
#(
    parameter int TW          = 16,
    parameter int TUNE_W      = 5,
    parameter int SYNC_STAGES = 2,
    parameter int PRESCALE    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_async,
    input  logic [TW-1:0]     cfg_expect,
    input  logic [TW-1:0]     cfg_tol,
    input  logic [1:0]        cfg_edge,
    output logic [TW-1:0]     cap_first,
    output logic [TW-1:0]     cap_last,
    output logic [TW-1:0]     meas_delta,
    output logic [TUNE_W-1:0] tune_code,
    output logic              cap_stb,
    output logic              meas_done
);
    ptrim_state_e  state_q;
    ptrim_state_e  state_d;
    logic          hit;
    logic [TW-1:0] now;
    logic          eval_now;
    trim_dir_e     dir;

    ptrim_evt_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .PRESCALE    (PRESCALE)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_async (evt_async),
        .edge_sel  (cfg_edge),
        .hit       (hit)
    );

    ptrim_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .count (now)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARM;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:  if (hit) state_d = ST_SPAN;
            ST_SPAN: if (hit) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_ARM;
            default: state_d = ST_ARM;
        endcase
    end

    // outputs and capture datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_first  <= '0;
            cap_last   <= '0;
            meas_delta <= '0;
            cap_stb    <= 1'b0;
            meas_done  <= 1'b0;
        end else begin
            cap_stb   <= 1'b0;
            meas_done <= (state_q == ST_EVAL);
            unique case (state_q)
                ST_ARM: begin
                    if (hit) begin
                        cap_first <= now;
                        cap_stb   <= 1'b1;
                    end
                end
                ST_SPAN: begin
                    if (hit) begin
                        cap_last   <= now;
                        meas_delta <= now - cap_first;
                        cap_stb    <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign eval_now = (state_q == ST_EVAL);

    ptrim_judge #(.TW(TW)) u_judge (
        .delta      (meas_delta),
        .expect_cnt (cfg_expect),
        .tol        (cfg_tol),
        .dir        (dir)
    );

    ptrim_tune #(.TUNE_W(TUNE_W)) u_tune (
        .clk   (clk),
        .rst_n (rst_n),
        .apply (eval_now),
        .dir   (dir),
        .code  (tune_code)
    );

endmodule

// File: rtl/ptrim_ctrl_chk.sv
module ptrim_ctrl_chk #(
    parameter int TW     = 16,
    parameter int TUNE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TW-1:0]     cfg_expect,
    input logic [TW-1:0]     cfg_tol,
    input logic [TW-1:0]     cap_first,
    input logic [TW-1:0]     cap_last,
    input logic [TW-1:0]     meas_delta,
    input logic [TUNE_W-1:0] tune_code,
    input logic              cap_stb,
    input logic              meas_done
);
    localparam logic [TUNE_W-1:0] CODE_MAX = {1'b0, {(TUNE_W-1){1'b1}}};
    localparam logic [TUNE_W-1:0] CODE_MIN = {1'b1, {(TUNE_W-1){1'b0}}};
    localparam logic [TUNE_W-1:0] ONE      = TUNE_W'(1);

    logic above_band;
    logic below_band;

    assign above_band = ({1'b0, meas_delta} > ({1'b0, cfg_expect} + {1'b0, cfg_tol}));
    assign below_band = (({1'b0, meas_delta} + {1'b0, cfg_tol}) < {1'b0, cfg_expect});

    p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> !cap_stb);

    p_delta_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |-> (meas_delta == TW'(cap_last - cap_first)));

    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && above_band && ($past(tune_code) != CODE_MIN))
        |-> (tune_code == TUNE_W'($past(tune_code) - ONE)));

    p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && below_band && ($past(tune_code) != CODE_MAX))
        |-> (tune_code == TUNE_W'($past(tune_code) + ONE)));

    p_band_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && !above_band && !below_band) |-> $stable(tune_code));

    p_no_wrap_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && ($past(tune_code) == CODE_MAX)) |-> (tune_code != CODE_MIN));

    p_no_wrap_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && ($past(tune_code) == CODE_MIN)) |-> (tune_code != CODE_MAX));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> !meas_done);

    p_tune_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_done |-> $stable(tune_code));

endmodule

bind ptrim_ctrl ptrim_ctrl_chk #(
    .TW     (TW),
    .TUNE_W (TUNE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_expect (cfg_expect),
    .cfg_tol    (cfg_tol),
    .cap_first  (cap_first),
    .cap_last   (cap_last),
    .meas_delta (meas_delta),
    .tune_code  (tune_code),
    .cap_stb    (cap_stb),
    .meas_done  (meas_done)
);

// File: tb/ptrim_ctrl_test.sv
`timescale 1ns/1ps
module ptrim_ctrl_test;
    localparam int TW     = 10;
    localparam int TUNE_W = 5;
    localparam int MASK   = (1 << TW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_async = 1'b0;
    logic [TW-1:0]     cfg_expect = '0;
    logic [TW-1:0]     cfg_tol = '0;
    logic [1:0]        cfg_edge = 2'b00;
    logic [TW-1:0]     cap_first;
    logic [TW-1:0]     cap_last;
    logic [TW-1:0]     meas_delta;
    logic [TUNE_W-1:0] tune_code;
    logic              cap_stb;
    logic              meas_done;

    ptrim_ctrl #(.TW(TW), .TUNE_W(TUNE_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_async  (evt_async),
        .cfg_expect (cfg_expect),
        .cfg_tol    (cfg_tol),
        .cfg_edge   (cfg_edge),
        .cap_first  (cap_first),
        .cap_last   (cap_last),
        .meas_delta (meas_delta),
        .tune_code  (tune_code),
        .cap_stb    (cap_stb),
        .meas_done  (meas_done)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    model_tune = 0;
    int    n_pushed = 0;
    int    n_seen = 0;
    int    n_stb = 0;
    int    n_wrap = 0;
    int    first_seen = 0;
    bit    finished = 1'b0;
    int    exp_delta_q[$];
    int    exp_tune_q[$];
    string exp_req_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int tune_int(input logic [TUNE_W-1:0] c);
        return int'($signed(c));
    endfunction

    // driver side: compute expected result from the requirements
    task automatic push_meas(input int d);
        int    step;
        int    nxt;
        string req;
        step = 0;
        if (d > int'(cfg_expect) + int'(cfg_tol))      step = -1;
        else if (d + int'(cfg_tol) < int'(cfg_expect)) step = 1;
        nxt = model_tune + step;
        if (step < 0)      req = "R5";
        else if (step > 0) req = "R6";
        else               req = "R7";
        if (nxt > 15)  begin nxt = 15;  req = "R8"; end
        if (nxt < -16) begin nxt = -16; req = "R8"; end
        model_tune = nxt;
        exp_delta_q.push_back(d & MASK);
        exp_tune_q.push_back(nxt);
        exp_req_q.push_back(req);
        n_pushed++;
    endtask

    task automatic pulse(input int width, input int gap);
        evt_async = 1'b1;
        repeat (width) @(negedge clk);
        evt_async = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic meas_rise(input int p);
        push_meas(p);
        pulse(4, p - 4);
        pulse(4, p - 4);
    endtask

    // falling edges: first pulse width 4, second width w2
    task automatic meas_fall(input int p, input int w2);
        push_meas(p + w2 - 4);
        pulse(4, p - 4);
        pulse(w2, p - w2 + 8);
    endtask

    task automatic meas_quad(input int p);
        push_meas(4 * p);
        for (int k = 0; k < 8; k++) pulse(4, p - 4);
    endtask

    // monitor: pops expected items when the design reports a result
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cap_stb) begin
                n_stb++;
                if ((n_stb % 2) == 1) first_seen = int'(cap_first);
            end
            if (meas_done) begin
                n_seen++;
                if (exp_delta_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected meas_done", n_seen, n_pushed);
                end else begin
                    int    ed;
                    int    et;
                    string er;
                    ed = exp_delta_q.pop_front();
                    et = exp_tune_q.pop_front();
                    er = exp_req_q.pop_front();
                    check(int'(meas_delta) == ed, "R4", "meas_delta", int'(meas_delta), ed);
                    check(tune_int(tune_code) == et, er, "tune_code", tune_int(tune_code), et);
                    check(int'(cap_first) == first_seen, "R3", "cap_first held",
                          int'(cap_first), first_seen);
                    check(int'(cap_last) == ((int'(cap_first) + ed) & MASK), "R4",
                          "cap_last", int'(cap_last), (int'(cap_first) + ed) & MASK);
                    if (cap_last < cap_first) n_wrap++;
                end
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check(tune_code == '0, "R1", "tune_code", tune_int(tune_code), 0);
        check(cap_first == '0, "R1", "cap_first", int'(cap_first), 0);
        check(meas_delta == '0, "R1", "meas_delta", int'(meas_delta), 0);
        check(cap_stb == 1'b0, "R1", "cap_stb", int'(cap_stb), 0);
        check(meas_done == 1'b0, "R1", "meas_done", int'(meas_done), 0);
        rst_n = 1'b1;
        cfg_expect = TW'(200);
        cfg_tol    = TW'(5);
        cfg_edge   = 2'b00;
        repeat (5) @(negedge clk);

        // R7 band and its edges, R5/R6 steps just outside
        meas_rise(200);
        meas_rise(205);
        meas_rise(195);
        meas_rise(206);
        meas_rise(194);
        meas_rise(220);
        meas_rise(180);

        // R2 falling edges: rising spacing 200 would hold, falling spacing 226 steps down
        cfg_edge = 2'b01;
        repeat (4) @(negedge clk);
        meas_fall(200, 30);

        // R2 select 11 behaves as rising
        cfg_edge = 2'b11;
        repeat (4) @(negedge clk);
        meas_rise(180);

        // R2 every fourth rising edge
        cfg_edge = 2'b10;
        repeat (4) @(negedge clk);
        meas_quad(50);
        meas_quad(45);

        // R8 saturation at both ends, R10 back-to-back pairs
        cfg_edge = 2'b00;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 18; k++) meas_rise(150);
        for (int k = 0; k < 34; k++) meas_rise(250);

        repeat (20) @(negedge clk);
        check(exp_delta_q.size() == 0, "R10", "pending results", exp_delta_q.size(), 0);
        check(n_seen == n_pushed, "R10", "measurement count", n_seen, n_pushed);
        check(n_stb == 2 * n_pushed, "R3", "capture strobes", n_stb, 2 * n_pushed);
        check(n_wrap > 0, "R4", "intervals spanning timer wrap", n_wrap, 1);
        check(tune_int(tune_code) == -16, "R8", "final tune_code", tune_int(tune_code), -16);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule